// File: doc/BRIEF.md
# Key-Unlocked Configuration Port

This block is the configuration-space front end of a multi-function I/O controller. The host reaches it through two byte-wide I/O locations: an index port at 0x2E and a data port at 0x2F. After reset the configuration space is sealed. The host opens it by writing a four-byte key to the index port. Once the block is open, the host writes a register number to the index port. It then reads or writes that register through the data port.

Register numbers below 0x30 are global. They are the logical-device selector at 0x07, a read-only 16-bit chip identifier at 0x20 (high byte) and 0x21 (low byte), and a revision whose low nibble sits at 0x22. Register numbers from 0x30 upward go to a bank of per-device storage, and the selector picks the bank. Each device bank has an activate byte at 0x30, a 16-bit base address at 0x60/0x61, and a window of device-specific bytes starting at 0x70. The host closes the configuration space by writing 0x02 to register 0x02. The devices that use these registers are outside this block.

Top module: `cfg_port_top`

## Requirements
- R1: After reset the block is locked, the index register is 0x00, the selector is 0x00 and every per-device register is 0x00.
- R2: The block opens only on the index-port write that completes the byte sequence 0x87, 0x01, 0x55, 0x55 in that order. Bytes written in any other order leave it locked.
- R3: While the block is locked, an index-port byte that does not match the expected key byte restarts matching. Such a byte counts as the first key byte when it is 0x87.
- R4: While the block is locked, data-port writes are ignored, index-port writes do not change the index register, and reads of either port return 0xFF.
- R5: While the block is open, an index-port write sets the index register and an index-port read returns it. Data-port accesses reach the register that the index selects.
- R6: Register 0x20 reads the identifier high byte and register 0x21 reads the identifier low byte. Register 0x22 reads the revision in bits 3:0 with bits 7:4 zero. Writes to these three registers have no effect.
- R7: Register 0x07 is a read/write selector. For a selector value below NUM_LDN, registers 0x30, 0x60, 0x61 and 0x70 to 0x70+EXT_REGS-1 are separate storage for each device.
- R8: When the selector is NUM_LDN or above, per-device registers read 0x00 and writes to them are ignored. No other bank is touched.
- R9: Register numbers that are not implemented read 0x00 and ignore writes.
- R10: A data-port write of 0x02 while the index is 0x02 locks the block. Any other value written there has no effect. All register contents and the selector survive locking and unlocking.
- R11: Accesses to I/O addresses other than the two ports change nothing, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0xFF when not reading an open port |

## Verification
The hardest situations to reach from the ports are partial key matches. Examples are a wrong byte after three correct ones, a repeated 0x87, and a selector value whose low bits alias an existing bank. Random index writes almost never form such patterns. Directed sequences therefore build each one explicitly, and each is checked by reading the data port before the completing byte and after it. A seeded random phase then mixes index and data traffic, occasional exits and re-entries, and selector values beyond the last device. Every read is compared against a bench register model.

// File: rtl/cfg_pkg.sv
// Shared constants and types for the configuration port.
// Assumes byte-wide registers and an 8-bit register number space.
package cfg_pkg;
    localparam logic [7:0] KEY_B0      = 8'h87;
    localparam logic [7:0] KEY_B1      = 8'h01;
    localparam logic [7:0] KEY_B2      = 8'h55;
    localparam logic [7:0] KEY_B3      = 8'h55;
    localparam logic [7:0] REG_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_CMD    = 8'h02;
    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_ID_HI   = 8'h20;
    localparam logic [7:0] REG_ID_LO   = 8'h21;
    localparam logic [7:0] REG_REV     = 8'h22;
    localparam logic [7:0] BANK_FIRST  = 8'h30;
    localparam logic [7:0] REG_ACT     = 8'h30;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
    localparam logic [7:0] REG_EXT0    = 8'h70;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_GOT3,
        KS_OPEN
    } key_state_t;

    // Expected key byte for a given match position
    function automatic logic [7:0] key_byte(input logic [1:0] pos);
        case (pos)
            2'd0:    key_byte = KEY_B0;
            2'd1:    key_byte = KEY_B1;
            2'd2:    key_byte = KEY_B2;
            default: key_byte = KEY_B3;
        endcase
    endfunction
endpackage

// File: rtl/cfg_unlock.sv
// Unlock sequencer: matches the four-byte key written to the index port
// while locked, and returns to locked on an exit request.
// Assumes idx_wr is a single-cycle strobe for an index-port write.
module cfg_unlock
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       unlocked
);
    key_state_t state_q, state_d;

    // Next-state logic for key matching and exit
    always_comb begin
        state_d = state_q;
        if (state_q == KS_OPEN) begin
            if (exit_req)
                state_d = KS_IDLE;
        end else if (idx_wr) begin
            if (wdata == key_byte(state_q[1:0])) begin
                case (state_q)
                    KS_IDLE: state_d = KS_GOT1;
                    KS_GOT1: state_d = KS_GOT2;
                    KS_GOT2: state_d = KS_GOT3;
                    default: state_d = KS_OPEN;
                endcase
            end else if (wdata == KEY_B0) begin
                state_d = KS_GOT1;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= KS_IDLE;
        else
            state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/cfg_index_regs.sv
// Index register, device selector and global read-only registers.
// Also detects the exit command. Assumes writes arrive already qualified
// by the unlocked state.
module cfg_index_regs
    import cfg_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'hA5C3,
    parameter logic [3:0]  CHIP_REV = 4'h6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic [7:0] index_q,
    output logic [7:0] ldn_q,
    output logic       glob_hit,
    output logic [7:0] glob_rdata,
    output logic       exit_req
);
    // Index and selector storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else begin
            if (idx_wr)
                index_q <= wdata;
            if (data_wr && index_q == REG_LDN)
                ldn_q <= wdata;
        end
    end

    // Read data for the global register region
    always_comb begin
        case (index_q)
            REG_LDN:   glob_rdata = ldn_q;
            REG_ID_HI: glob_rdata = CHIP_ID[15:8];
            REG_ID_LO: glob_rdata = CHIP_ID[7:0];
            REG_REV:   glob_rdata = {4'h0, CHIP_REV};
            default:   glob_rdata = 8'h00;
        endcase
    end

    assign glob_hit = (index_q < BANK_FIRST);
    assign exit_req = data_wr && (index_q == REG_EXIT) && (wdata == EXIT_CMD);
endmodule

// File: rtl/cfg_bank_store.sv
// Per-device register banks selected by the logical device number.
// Each bank holds an activate byte, a 16-bit base address and EXT_REGS
// device-specific bytes. Selector values at or above NUM_LDN reach no bank.
module cfg_bank_store
    import cfg_pkg::*;
#(
    parameter int NUM_LDN  = 11,
    parameter int EXT_REGS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] ldn,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int SLOTS = 3 + EXT_REGS;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic [SLOT_W-1:0] slot;
    logic              slot_hit;
    logic              ldn_hit;
    logic [LDN_W-1:0]  ldn_sel;
    logic [7:0]        dev_rd [NUM_LDN];

    // Map the register number onto a storage slot
    always_comb begin
        slot     = '0;
        slot_hit = 1'b0;
        if (index == REG_ACT) begin
            slot     = SLOT_W'(0);
            slot_hit = 1'b1;
        end else if (index == REG_BASE_HI) begin
            slot     = SLOT_W'(1);
            slot_hit = 1'b1;
        end else if (index == REG_BASE_LO) begin
            slot     = SLOT_W'(2);
            slot_hit = 1'b1;
        end else if (int'(index) >= int'(REG_EXT0) &&
                     int'(index) < int'(REG_EXT0) + EXT_REGS) begin
            slot     = SLOT_W'(3 + int'(index) - int'(REG_EXT0));
            slot_hit = 1'b1;
        end
    end

    assign ldn_hit = (int'(ldn) < NUM_LDN);
    assign ldn_sel = ldn[LDN_W-1:0];

    for (genvar d = 0; d < NUM_LDN; d++) begin : g_dev
        logic [7:0] regs [SLOTS];

        // Storage for one device bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SLOTS; s++)
                    regs[s] <= 8'h00;
            end else if (wr_en && slot_hit && int'(ldn) == d) begin
                regs[slot] <= wdata;
            end
        end

        assign dev_rd[d] = regs[slot];
    end

    // Read mux across banks
    always_comb begin
        if (slot_hit && ldn_hit)
            rdata = dev_rd[ldn_sel];
        else
            rdata = 8'h00;
    end
endmodule

// File: rtl/cfg_port_top.sv
// Configuration port top: decodes the index and data I/O locations,
// gates access by the unlock sequencer and muxes read data.
// Assumes one access strobe per cycle; read data is combinational.
module cfg_port_top
    import cfg_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter int          NUM_LDN    = 11,
    parameter int          EXT_REGS   = 16,
    parameter logic [15:0] CHIP_ID    = 16'hA5C3,
    parameter logic [3:0]  CHIP_REV   = 4'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(INDEX_ADDR);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(INDEX_ADDR) + ADDR_W'(1);

    logic       hit_idx, hit_dat;
    logic       unlocked;
    logic       idx_wr_any, idx_wr_open, data_wr_open;
    logic       exit_req;
    logic [7:0] cur_index, cur_ldn;
    logic       glob_hit;
    logic [7:0] glob_rdata, bank_rdata;

    assign hit_idx      = (io_addr == IDX_A);
    assign hit_dat      = (io_addr == DAT_A);
    assign idx_wr_any   = io_wr && hit_idx;
    assign idx_wr_open  = idx_wr_any && unlocked;
    assign data_wr_open = io_wr && hit_dat && unlocked;

    cfg_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr_any),
        .wdata    (io_wdata),
        .exit_req (exit_req),
        .unlocked (unlocked)
    );

    cfg_index_regs #(
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr_open),
        .data_wr    (data_wr_open),
        .wdata      (io_wdata),
        .index_q    (cur_index),
        .ldn_q      (cur_ldn),
        .glob_hit   (glob_hit),
        .glob_rdata (glob_rdata),
        .exit_req   (exit_req)
    );

    cfg_bank_store #(
        .NUM_LDN  (NUM_LDN),
        .EXT_REGS (EXT_REGS)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (data_wr_open),
        .index (cur_index),
        .ldn   (cur_ldn),
        .wdata (io_wdata),
        .rdata (bank_rdata)
    );

    // Read data selection: 0xFF unless an open port is read
    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && unlocked) begin
            if (hit_idx)
                io_rdata = cur_index;
            else if (hit_dat)
                io_rdata = glob_hit ? glob_rdata : bank_rdata;
        end
    end
endmodule

// File: rtl/cfg_port_chk.sv
// Checker for the configuration port, bound to the top module.
// Observes ports plus the lock state, index and selector.
module cfg_port_chk #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] CHIP_ID    = 16'hA5C3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              unlocked,
    input logic [7:0]        cur_index,
    input logic [7:0]        cur_ldn
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(INDEX_ADDR);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(INDEX_ADDR) + ADDR_W'(1);

    // R4: reads while locked return all ones
    p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && io_rd) |-> (io_rdata == 8'hFF));

    // R4: index register holds while locked
    p_locked_index_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(cur_index));

    // R2: opening follows an index-port write of the final key byte
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(io_wr && io_addr == IDX_A && io_wdata == 8'h55));

    // R10: exit command locks on the next cycle
    p_exit_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_wr && io_addr == DAT_A && cur_index == 8'h02 &&
         io_wdata == 8'h02) |=> !unlocked);

    // R7: selector changes only through a data write to register 0x07
    p_ldn_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && io_wr && io_addr == DAT_A && cur_index == 8'h07)
        |=> $stable(cur_ldn));

    // R6: identifier high byte reads back constant
    p_id_hi_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && io_rd && io_addr == DAT_A && cur_index == 8'h20)
        |-> (io_rdata == CHIP_ID[15:8]));
endmodule

bind cfg_port_top cfg_port_chk #(
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR),
    .CHIP_ID    (CHIP_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .unlocked  (unlocked),
    .cur_index (cur_index),
    .cur_ldn   (cur_ldn)
);

// File: tb/cfg_port_top_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a register model kept in the bench.
module cfg_port_top_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          NUM_LDN    = 11;
    localparam int          EXT_REGS   = 16;
    localparam logic [15:0] CHIP_ID    = 16'hA5C3;
    localparam logic [3:0]  CHIP_REV   = 4'h6;
    localparam logic [15:0] IDX        = 16'h002E;
    localparam logic [15:0] DAT        = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Register model
    bit         m_open;
    int         m_kpos;
    logic [7:0] m_index;
    logic [7:0] m_ldn;
    logic [7:0] m_bank [NUM_LDN][128];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_top #(
        .NUM_LDN  (NUM_LDN),
        .EXT_REGS (EXT_REGS),
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata)
    );

    function automatic bit bank_impl(input logic [7:0] idx);
        return idx == 8'h30 || idx == 8'h60 || idx == 8'h61 ||
               (int'(idx) >= 'h70 && int'(idx) < 'h70 + EXT_REGS);
    endfunction

    function automatic logic [7:0] key_at(input int p);
        case (p)
            0: return 8'h87;
            1: return 8'h01;
            default: return 8'h55;
        endcase
    endfunction

    function automatic logic [7:0] exp_reg();
        case (m_index)
            8'h07: return m_ldn;
            8'h20: return CHIP_ID[15:8];
            8'h21: return CHIP_ID[7:0];
            8'h22: return {4'h0, CHIP_REV};
            default: begin
                if (bank_impl(m_index) && int'(m_ldn) < NUM_LDN)
                    return m_bank[int'(m_ldn)][m_index[6:0]];
                return 8'h00;
            end
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        if (!m_open) return 8'hFF;
        if (a == IDX) return m_index;
        if (a == DAT) return exp_reg();
        return 8'hFF;
    endfunction

    function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
        if (a == IDX) begin
            if (m_open) begin
                m_index = d;
            end else if (d == key_at(m_kpos)) begin
                m_kpos++;
                if (m_kpos == 4) begin
                    m_open = 1'b1;
                    m_kpos = 0;
                end
            end else begin
                m_kpos = (d == 8'h87) ? 1 : 0;
            end
        end else if (a == DAT && m_open) begin
            if (m_index == 8'h02) begin
                if (d == 8'h02) begin
                    m_open = 1'b0;
                    m_kpos = 0;
                end
            end else if (m_index == 8'h07) begin
                m_ldn = d;
            end else if (bank_impl(m_index) && int'(m_ldn) < NUM_LDN) begin
                m_bank[int'(m_ldn)][m_index[6:0]] = d;
            end
        end
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        #1;
        check(tag, io_rdata, exp_rd(a));
        io_rd   = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(IDX, idx);
        wr(DAT, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, input string tag);
        wr(IDX, idx);
        rd(DAT, tag);
    endtask

    task automatic unlock();
        wr(IDX, 8'h87);
        wr(IDX, 8'h01);
        wr(IDX, 8'h55);
        wr(IDX, 8'h55);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic logic [7:0] pick_idx(input int r);
        case (r % 12)
            0: return 8'h07;
            1: return 8'h20;
            2: return 8'h21;
            3: return 8'h22;
            4: return 8'h30;
            5: return 8'h60;
            6: return 8'h61;
            7: return 8'h10;
            8: return 8'h40;
            9: return 8'h02;
            10: return 8'h80;
            default: return 8'(8'h70 + (r % EXT_REGS));
        endcase
    endfunction

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    // Main stimulus
    initial begin
        m_open = 1'b0;
        m_kpos = 0;
        m_index = 8'h00;
        m_ldn = 8'h00;
        for (int d = 0; d < NUM_LDN; d++)
            for (int i = 0; i < 128; i++)
                m_bank[d][i] = 8'h00;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4: reset state is locked
        rd(IDX, "R1 locked index read");
        rd(DAT, "R1 locked data read");

        // R4: locked writes ignored
        wr(IDX, 8'h30);
        wr(DAT, 8'hAA);
        rd(DAT, "R4 locked data read after write");

        // R2: out-of-order key stays locked
        wr(IDX, 8'h01);
        wr(IDX, 8'h87);
        wr(IDX, 8'h55);
        wr(IDX, 8'h55);
        rd(DAT, "R2 out-of-order key");

        // R3: wrong byte after three correct ones restarts
        wr(IDX, 8'h87);
        wr(IDX, 8'h01);
        wr(IDX, 8'h55);
        wr(IDX, 8'h12);
        rd(IDX, "R3 wrong fourth byte");
        wr(IDX, 8'h55);
        rd(IDX, "R3 no resume after restart");

        // R3: repeated 0x87 counts as first byte
        wr(IDX, 8'h87);
        wr(IDX, 8'h87);
        wr(IDX, 8'h01);
        wr(IDX, 8'h55);
        rd(DAT, "R2 three bytes not enough");
        wr(IDX, 8'h55);
        rd(IDX, "R3 repeated 0x87 then open, index R1 R4");

        // R1: selector and bank reset values
        reg_rd(8'h07, "R1 selector reset");
        reg_rd(8'h30, "R1 bank reset R4");

        // R6: identity registers
        reg_rd(8'h20, "R6 id high");
        reg_rd(8'h21, "R6 id low");
        reg_rd(8'h22, "R6 revision");
        reg_wr(8'h20, 8'hFF);
        rd(DAT, "R6 id write ignored");
        reg_wr(8'h22, 8'hFF);
        rd(DAT, "R6 revision write ignored");

        // R7: separate banks
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h30, 8'h11);
        reg_wr(8'h60, 8'h22);
        reg_wr(8'h61, 8'h2B);
        reg_wr(8'h7F, 8'h33);
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h44);
        reg_rd(8'h60, "R7 bank 9 base untouched");
        reg_rd(8'h30, "R7 bank 9 activate");
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h30, "R7 bank 3 activate");
        reg_rd(8'h61, "R7 bank 3 base low");
        reg_rd(8'h7F, "R7 bank 3 last ext");
        reg_rd(8'h07, "R7 selector readback R5");

        // R8: selector beyond last device, including aliasing low bits
        reg_wr(8'h07, 8'h13);
        reg_wr(8'h30, 8'h55);
        rd(DAT, "R8 out-of-range bank read");
        reg_wr(8'h07, 8'(NUM_LDN));
        reg_wr(8'h30, 8'h66);
        rd(DAT, "R8 first invalid selector");
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h30, "R8 bank 3 not aliased");
        reg_wr(8'h07, 8'h00);
        reg_rd(8'h30, "R8 bank 0 not aliased");

        // R9: unimplemented registers
        reg_wr(8'h40, 8'h77);
        rd(DAT, "R9 unimplemented 0x40");
        reg_wr(8'h80, 8'h78);
        rd(DAT, "R9 past ext window");
        reg_rd(8'h10, "R9 global gap");

        // R11: other addresses
        wr(16'h002C, 8'h31);
        rd(16'h002C, "R11 foreign address read");
        rd(IDX, "R11 index unchanged");

        // R10: exit handling
        reg_wr(8'h02, 8'h05);
        rd(IDX, "R10 wrong exit value stays open");
        wr(DAT, 8'h02);
        rd(IDX, "R10 exit locks index port");
        rd(DAT, "R10 exit locks data port");
        unlock();
        reg_rd(8'h07, "R10 selector retained");
        reg_wr(8'h07, 8'h09);
        reg_rd(8'h30, "R10 bank retained");

        // Random phase (R5, R7, R8, R10)
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 8);
            if (!m_open && ($urandom % 3) == 0)
                unlock();
            case (op)
                0, 1: wr(IDX, pick_idx(int'($urandom % 1000)));
                2, 3: begin
                    if (m_index == 8'h07)
                        wr(DAT, 8'($urandom % (NUM_LDN + 3)));
                    else
                        wr(DAT, 8'($urandom));
                end
                4, 5: rd(DAT, "R5 random data read");
                6: rd(IDX, "R5 random index read");
                default: begin
                    if (($urandom % 4) == 0) begin
                        reg_wr(8'h02, 8'h02);
                        rd(DAT, "R10 random exit");
                    end else begin
                        wr(IDX, 8'($urandom));
                    end
                end
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule